// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from the system clock. An 8-bit timer counts up to a programmed period value and then restarts. Each timer step lasts four clock cycles times a selectable prescale factor. Two fine bits below the timer give a 10-bit timebase, and the output's falling edge is placed by comparing that timebase with the duty value.

Software programs the period, the duty value, the mode and the prescale factor through a small register write port. The requested duty is buffered. It moves into the active duty register only when a period ends, so a change written partway through a period never produces a short or torn pulse. The active duty value is brought out on a read-only port. The block also provides a one-cycle pulse at the start of each period and an output-enable flag for the pad logic.

Top module: `pwm10_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `pwm_out`, `pwm_oe` and `period_match` are 0 and `duty_active` is 0.
- R2: With period value P (written at address 0) and prescale factor N, one PWM period lasts (P+1)·4·N clock cycles. `period_match` is high for exactly one cycle, the first cycle of each period.
- R3: The prescale select (address 3, bits [1:0]) gives N=1 for code 0, N=4 for code 1 and N=16 for codes 2 and 3. The fine bits below the timer advance once every N clock cycles.
- R4: The 10-bit duty D is formed from the byte at address 1 (D[9:2]) and bits [5:4] of the control register at address 2 (D[1:0]). With 0 < D < 4·(P+1), the output rises at the start of each period and stays high for exactly D·N clock cycles.
- R5: When the active duty is 0, the output is not set at the period start and stays low for the whole period.
- R6: When the active duty is greater than or equal to 4·(P+1), the output stays high for the whole period.
- R7: `duty_active` takes the requested duty only in the cycle where `period_match` is high. A duty write made mid-period leaves the current period's high time unchanged.
- R8: PWM mode is selected when control bits [3:2] equal 2'b11. `pwm_oe` is high only in that mode. In any other mode, including a cleared control register, the output is forced low at once, the timebase is held at zero, and `period_match` stays low.
- R9: After PWM mode is entered, the output stays low until the first `period_match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high byte, 2 control, 3 prescale |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| pwm_oe | output | 1 | Output enable, high while PWM mode is selected |
| period_match | output | 1 | One-cycle pulse in the first cycle of each period |
| duty_active | output | 10 | Active (latched) duty value, read-only |

## Verification
The bench builds the block with its default 8-bit timer. It then programs small period values (1 to 9), so that every prescale ratio finishes a full period within 128 clock cycles. This makes it possible to measure whole periods at all three prescale ratios, including the 16-clock fine step. It also reaches the duty limits: zero, exactly the full period count, and the 10-bit maximum. The mid-period duty rewrite is placed a known number of cycles after `period_match`, so the leftover high time of the old duty can be predicted to the cycle.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int FINE_W = 2;
    localparam int SUB_W  = 6;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        ADDR_PERIOD  = 2'd0,
        ADDR_DUTY_HI = 2'd1,
        ADDR_CTRL    = 2'd2,
        ADDR_PRESC   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV4  = 2'd1,
        PS_DIV16 = 2'd2,
        PS_DIV16B = 2'd3
    } presc_e;

    // last value of the sub-step counter for one timer step
    function automatic logic [SUB_W-1:0] sub_last(input presc_e ps);
        case (ps)
            PS_DIV1: sub_last = SUB_W'(3);
            PS_DIV4: sub_last = SUB_W'(15);
            default: sub_last = SUB_W'(63);
        endcase
    endfunction

    // fine bits: the two bits just above the prescaler divide
    function automatic logic [FINE_W-1:0] fine_of(input logic [SUB_W-1:0] sub,
                                                  input presc_e ps);
        case (ps)
            PS_DIV1: fine_of = sub[1:0];
            PS_DIV4: fine_of = sub[3:2];
            default: fine_of = sub[5:4];
        endcase
    endfunction

    function automatic logic is_pwm_mode(input logic [MODE_W-1:0] mode);
        is_pwm_mode = (mode[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm10_pkg::*;
#(
    parameter int CNT_W  = 8,
    localparam int DUTY_W = CNT_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  period,
    output logic [DUTY_W-1:0] duty_req,
    output logic [MODE_W-1:0] mode,
    output presc_e            presc
);

    logic [CNT_W-1:0]  duty_hi_q;
    logic [FINE_W-1:0] duty_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period    <= '0;
            duty_hi_q <= '0;
            duty_lo_q <= '0;
            mode      <= '0;
            presc     <= PS_DIV1;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_PERIOD:  period    <= wr_data;
                ADDR_DUTY_HI: duty_hi_q <= wr_data;
                ADDR_CTRL: begin
                    duty_lo_q <= wr_data[MODE_W+FINE_W-1:MODE_W];
                    mode      <= wr_data[MODE_W-1:0];
                end
                default:      presc     <= presc_e'(wr_data[1:0]);
            endcase
        end
    end

    assign duty_req = {duty_hi_q, duty_lo_q};

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm10_pkg::*;
#(
    parameter int CNT_W  = 8,
    localparam int DUTY_W = CNT_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  presc_e            presc,
    input  logic [CNT_W-1:0]  period,
    output logic [DUTY_W-1:0] tbase_nxt,
    output logic              boundary
);

    logic [SUB_W-1:0] sub_q, sub_nxt;
    logic [CNT_W-1:0] tmr_q, tmr_nxt;
    logic             step;

    always_comb begin
        step     = (sub_q >= sub_last(presc));
        boundary = run && step && (tmr_q == period);
        if (!run) begin
            sub_nxt = '0;
            tmr_nxt = '0;
        end else if (step) begin
            sub_nxt = '0;
            tmr_nxt = boundary ? '0 : tmr_q + 1'b1;
        end else begin
            sub_nxt = sub_q + 1'b1;
            tmr_nxt = tmr_q;
        end
        tbase_nxt = {tmr_nxt, fine_of(sub_nxt, presc)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            tmr_q <= '0;
        end else begin
            sub_q <= sub_nxt;
            tmr_q <= tmr_nxt;
        end
    end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              boundary,
    input  logic [DUTY_W-1:0] tbase_nxt,
    input  logic [DUTY_W-1:0] duty_req,
    output logic              pwm_out,
    output logic              period_match,
    output logic [DUTY_W-1:0] duty_active
);

    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q        <= 1'b0;
            period_match <= 1'b0;
            duty_active  <= '0;
        end else begin
            period_match <= boundary;
            if (boundary)
                duty_active <= duty_req;
            if (!run)
                out_q <= 1'b0;
            else if (boundary)
                out_q <= (duty_req != '0);
            else if (tbase_nxt == duty_active)
                out_q <= 1'b0;
        end
    end

    // a mode change drops the output in the same cycle
    assign pwm_out = out_q && run;

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int CNT_W  = 8,
    localparam int DUTY_W = CNT_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic              period_match,
    output logic [DUTY_W-1:0] duty_active
);

    logic [CNT_W-1:0]  period;
    logic [DUTY_W-1:0] duty_req;
    logic [MODE_W-1:0] mode;
    presc_e            presc;
    logic [DUTY_W-1:0] tbase_nxt;
    logic              boundary;
    logic              run;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .period(period), .duty_req(duty_req),
        .mode(mode), .presc(presc)
    );

    assign run    = is_pwm_mode(mode);
    assign pwm_oe = run;

    pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk(clk), .rst(rst), .run(run), .presc(presc), .period(period),
        .tbase_nxt(tbase_nxt), .boundary(boundary)
    );

    pwm_outstage #(.DUTY_W(DUTY_W)) u_out (
        .clk(clk), .rst(rst), .run(run), .boundary(boundary),
        .tbase_nxt(tbase_nxt), .duty_req(duty_req), .pwm_out(pwm_out),
        .period_match(period_match), .duty_active(duty_active)
    );

endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_out,
    input logic              pwm_oe,
    input logic              period_match,
    input logic [DUTY_W-1:0] duty_active
);

    // R8
    out_low_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_oe |-> !pwm_out);

    // R8
    no_match_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_oe |=> !period_match);

    // R2
    match_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        period_match |=> !period_match);

    // R4
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        (period_match && pwm_oe && duty_active != '0) |-> pwm_out);

    // R5
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (period_match && duty_active == '0) |-> !pwm_out);

    // R7
    duty_latch_at_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_active) |-> period_match);

endmodule

bind pwm10_gen pwm10_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk(clk), .rst(rst), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .period_match(period_match), .duty_active(duty_active)
);

// File: tb/tb_pwm10_gen.sv
module tb_pwm10_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, pwm_oe, period_match;
    logic [9:0] duty_active;

    int total_chk = 0;
    int bad_chk   = 0;

    always #2.5 clk = ~clk;

    pwm10_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .period_match(period_match), .duty_active(duty_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // program and enable; check the output stays low up to the first match (R9)
    task automatic setup(input int p, input int d, input int ps, input logic [3:0] mode);
        int hi_seen;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'(p));
        wr(2'd3, 8'(ps));
        wr(2'd1, 8'(d >> 2));
        wr(2'd2, {2'b00, 2'(d), mode});
        hi_seen = 0;
        for (int i = 0; i < 5000 && !period_match; i++) begin
            hi_seen += int'(pwm_out);
            @(negedge clk);
        end
        check(hi_seen == 0, "R9 low before first match", hi_seen, 0);
    endtask

    // starts at a negedge where period_match is high or waits for it
    task automatic measure(output int hi, output int total);
        for (int i = 0; i < 5000 && !period_match; i++) @(negedge clk);
        hi = 0; total = 0;
        do begin
            hi += int'(pwm_out);
            total++;
            @(negedge clk);
        end while (!period_match && total < 5000);
    endtask

    task automatic t_reset();
        check(pwm_out == 1'b0, "R1 pwm_out", int'(pwm_out), 0);
        check(pwm_oe == 1'b0, "R1 pwm_oe", int'(pwm_oe), 0);
        check(period_match == 1'b0, "R1 period_match", int'(period_match), 0);
        check(duty_active == 10'd0, "R1 duty_active", int'(duty_active), 0);
    endtask

    task automatic t_div1();
        int hi, tot;
        setup(9, 13, 0, 4'hC);
        measure(hi, tot);
        check(tot == 40, "R2 period div1", tot, 40);
        check(hi == 13, "R4 high time div1", hi, 13);
        check(duty_active == 10'd13, "R4 duty split", int'(duty_active), 13);
        check(pwm_oe == 1'b1, "R8 oe in mode C", int'(pwm_oe), 1);
    endtask

    task automatic t_div4();
        int hi, tot;
        setup(3, 5, 1, 4'hC);
        measure(hi, tot);
        check(tot == 64, "R3 period div4", tot, 64);
        check(hi == 20, "R3 high time div4", hi, 20);
    endtask

    task automatic t_div16();
        int hi, tot;
        setup(1, 3, 2, 4'hF);
        measure(hi, tot);
        check(tot == 128, "R3 period div16", tot, 128);
        check(hi == 48, "R3 high time div16", hi, 48);
        setup(1, 6, 3, 4'hD);
        measure(hi, tot);
        check(tot == 128, "R3 period code3", tot, 128);
        check(hi == 96, "R3 high time code3", hi, 96);
    endtask

    task automatic t_zero();
        int hi, tot;
        setup(4, 0, 0, 4'hC);
        measure(hi, tot);
        check(hi == 0, "R5 zero duty high time", hi, 0);
        check(tot == 20, "R5 zero duty period", tot, 20);
    endtask

    task automatic t_full();
        int hi, tot;
        setup(3, 16, 0, 4'hC);
        measure(hi, tot);
        check(hi == 16, "R6 duty equal full", hi, 16);
        setup(3, 1023, 1, 4'hC);
        measure(hi, tot);
        check(hi == 64 && tot == 64, "R6 duty max", hi, 64);
    endtask

    task automatic t_dbuf();
        int hi, tot, rest;
        setup(9, 8, 0, 4'hC);
        measure(hi, tot);
        check(hi == 8, "R7 baseline", hi, 8);
        // now in cycle 0 of a period; rewrite the duty high byte (D becomes 28)
        wr(2'd1, 8'd7);
        check(duty_active == 10'd8, "R7 active unchanged mid-period", int'(duty_active), 8);
        rest = 0;
        for (int i = 0; i < 100 && !period_match; i++) begin
            rest += int'(pwm_out);
            @(negedge clk);
        end
        check(rest == 6, "R7 current period keeps old duty", rest, 6);
        check(duty_active == 10'd28, "R7 latched at match", int'(duty_active), 28);
        measure(hi, tot);
        check(hi == 28, "R7 next period uses new duty", hi, 28);
    endtask

    task automatic t_mode();
        int hi, m;
        setup(9, 20, 0, 4'hC);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check(pwm_out == 1'b1, "R8 running high", int'(pwm_out), 1);
        wr(2'd2, 8'h00);
        check(pwm_out == 1'b0, "R8 cleared control forces low", int'(pwm_out), 0);
        check(pwm_oe == 1'b0, "R8 oe low when cleared", int'(pwm_oe), 0);
        wr(2'd2, 8'h08);
        hi = 0; m = 0;
        for (int i = 0; i < 60; i++) begin
            hi += int'(pwm_out);
            m  += int'(period_match);
            @(negedge clk);
        end
        check(hi == 0 && m == 0 && pwm_oe == 1'b0, "R8 mode 8 idle", hi + m, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_div1();
        t_div4();
        t_div16();
        t_zero();
        t_full();
        t_dbuf();
        t_mode();
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total_chk++;
        bad_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule